// File: doc/BRIEF.md
# Gated Multi-Source Clock Frequency Meter

This block measures the frequency of one clock out of a bank of up to 128 candidate clocks. Software picks a source index and a gate length in microseconds. The block then opens a gate window of exactly that length, timed from the system clock. While the gate is open it counts rising edges of the chosen clock in that clock's own domain. When the window closes, the 16-bit count is moved back into the system domain and stored in a result register. The busy flag then clears. A count that would pass 65535 is held at 0xFFFF, and software reads that value as "out of range, retry with a shorter gate".

All access goes through a small word-addressed register window. A control word holds the gate length, the source index, an enable, a start strobe, a continuous-mode flag and an interrupt enable. A read of that same word also returns the busy flag. The count is read back from a separate result word. The usual sequence is:

1. Clear the control word.
2. Program the length and the source.
3. Set enable and start together.
4. Poll busy until it reads low.
5. Clear enable and read the result.

In continuous mode the windows follow one another back to back, and the block pulses an interrupt line after each one.

Top module: `freq_meter`

## Requirements
- R1: Byte offset 0x4 is the control word and byte offset 0xC is the result word, with the count in bits [15:0] and zeros above. Offsets 0x0 and 0x8 read as zero, and writes to them change nothing.
- R2: The control word has these fields:
  - bits [15:0]: gate length minus one.
  - bit 16: enable.
  - bit 17: continuous mode.
  - bit 18: interrupt enable.
  - bit 19: start.
  - bits [26:20]: source index.
  - bit 31: busy, read-only.

  All writable fields read back as written. The start bit reads 0 once a measurement has begun.
- R3: From idle, busy reads 1 starting in the second clock cycle after the write that sets enable and start. It still reads 0 in the first cycle after that write.
- R4: A gate length of N gives a window of N+1 microseconds. One microsecond is TICK_DIV system clock cycles. The result equals the number of rising edges of the selected clock in that window, within plus or minus 2.
- R5: The source index selects which bit of `src_clks` is counted. Each index from 0 to NUM_SRC-1 measures its own clock.
- R6: A count that would go past 65535 reads as exactly 0xFFFF. A count below that limit is not clipped.
- R7: By the first cycle in which busy reads 0 after a measurement, the result word already holds that measurement's count.
- R8: With continuous mode set, each window starts as soon as the previous one completes. Busy stays at 1 between windows, and the result word updates after every window.
- R9: With interrupt enable set, `irq` is high for exactly one cycle at the end of each completed window. With interrupt enable clear, `irq` stays low.
- R10: Clearing enable while busy aborts the measurement. Busy reads 0 no later than the second cycle after that write, the result word keeps its previous value, and no interrupt fires. A later measurement works normally.
- R11: After reset, the control word, the result word and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the gate timer and registers run on it |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | 4 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_clks | input | NUM_SRC | Bank of clocks that can be measured |
| irq | output | 1 | One-cycle pulse at the end of each window when interrupts are enabled |

## Verification
The bench drives eight free-running clocks with distinct, incommensurate periods. It sweeps every source across short and long gate lengths and compares each count with the ideal value, worked out from the window length and the clock period. A mux that ignores the index or a window that is off by one microsecond misses that comparison by far more than the tolerance. A count just below 65535 must come back unclipped, and one just above must read 0xFFFF; a wrapping counter would instead return a small number. Aborts are placed mid-window in both single-shot and continuous mode. A design that captures on abort, keeps busy high, or fires a stray interrupt is caught by a result that changes or by an extra pulse. Continuous mode is checked for busy dropping between windows and for the interrupt count per window.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
package fm_pkg;
    // register window
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] OFS_SPARE_A = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_SPARE_B = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_RESULT  = 4'hC;

    // field widths fixed by the register layout
    localparam int LEN_W    = 16;
    localparam int SEL_W    = 7;
    localparam int CNT_W    = 16;
    localparam int BUSY_BIT = 31;

    // control word, MSB first: sel[26:20] start[19] irq_en[18] cont[17] en[16] len[15:0]
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             start;
        logic             irq_en;
        logic             cont;
        logic             en;
        logic [LEN_W-1:0] len;
    } fm_ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GATE  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_FLUSH = 2'd3
    } fm_state_e;
endpackage

// File: rtl/fm_sync.sv
`timescale 1ns/1ps
module fm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/fm_tick_gen.sv
`timescale 1ns/1ps
module fm_tick_gen #(
    parameter int TICK_DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick = (cnt_q == LAST);
        if (clr || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (TICK_DIV > 1) begin : g_gap
            // R4: microsecond ticks are isolated pulses
            p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/fm_edge_counter.sv
`timescale 1ns/1ps
module fm_edge_counter #(
    parameter int CNT_W = 16
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  logic             gate,
    output logic             active,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] SAT = '1;

    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t c_d, c_q;
    logic      gate_s;

    fm_sync #(.STAGES(2)) u_gate_sync (
        .clk   (sclk),
        .rst_n (rst_n),
        .d     (gate),
        .q     (gate_s)
    );

    always_comb begin
        c_d      = c_q;
        c_d.prev = gate_s;
        if (gate_s && !c_q.prev)
            c_d.cnt = CNT_W'(1);
        else if (gate_s && (c_q.cnt != SAT))
            c_d.cnt = c_q.cnt + 1'b1;
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign active = gate_s;
    assign count  = c_q.cnt;

    // R6: a full counter never wraps while the gate stays open
    p_sat_hold_r6: assert property (@(posedge sclk) disable iff (!rst_n)
        (c_q.cnt == SAT && c_q.prev && active) |=> (count == SAT));

    // R7: with the gate closed the count is frozen for the handshake
    p_frozen_r7: assert property (@(posedge sclk) disable iff (!rst_n)
        !active |=> $stable(count));
endmodule

// File: rtl/freq_meter.sv
`timescale 1ns/1ps
module freq_meter
    import fm_pkg::*;
#(
    parameter int NUM_SRC  = 128,
    parameter int TICK_DIV = 100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] src_clks,
    output logic               irq
);
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int CTRL_W = $bits(fm_ctrl_t);

    typedef struct packed {
        fm_state_e        st;
        fm_ctrl_t         ctrl;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] tk;
        logic             done;
        logic [SRC_W-1:0] src;
        logic             gate;
        logic [CNT_W-1:0] result;
        logic             irq;
    } regs_t;

    regs_t            r_d, r_q;
    logic             tick, tick_clr, ack_s, src_active, meas_clk;
    logic [CNT_W-1:0] src_count;
    logic             wr_ctrl, launch, win_end, busy;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata[31:CTRL_W];
    assign meas_clk     = src_clks[r_q.src];
    assign busy         = (r_q.st == ST_GATE) || (r_q.st == ST_DRAIN);
    assign irq          = r_q.irq;

    fm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    fm_edge_counter #(.CNT_W(CNT_W)) u_counter (
        .sclk   (meas_clk),
        .rst_n  (rst_n),
        .gate   (r_q.gate),
        .active (src_active),
        .count  (src_count)
    );

    fm_sync #(.STAGES(2)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (src_active),
        .q     (ack_s)
    );

    always_comb begin
        r_d      = r_q;
        r_d.irq  = 1'b0;
        tick_clr = 1'b0;
        launch   = 1'b0;
        wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
        win_end  = r_q.done || (tick && (r_q.tk == r_q.len));

        if (wr_ctrl) r_d.ctrl = fm_ctrl_t'(bus_wdata[CTRL_W-1:0]);

        unique case (r_q.st)
            ST_IDLE: launch = r_q.ctrl.en && r_q.ctrl.start;
            ST_GATE: begin
                if (!r_q.ctrl.en) begin
                    r_d.st   = ST_FLUSH;
                    r_d.gate = 1'b0;
                end else if (win_end && ack_s) begin
                    r_d.st   = ST_DRAIN;
                    r_d.gate = 1'b0;
                end else if (win_end) begin
                    r_d.done = 1'b1;
                end else if (tick) begin
                    r_d.tk = r_q.tk + 1'b1;
                end
            end
            ST_DRAIN: begin
                if (!r_q.ctrl.en) begin
                    r_d.st = ST_FLUSH;
                end else if (!ack_s) begin
                    r_d.result = src_count;
                    r_d.irq    = r_q.ctrl.irq_en;
                    if (r_q.ctrl.cont) launch = 1'b1;
                    else               r_d.st = ST_IDLE;
                end
            end
            ST_FLUSH: if (!ack_s) r_d.st = ST_IDLE;
            default:  r_d.st = ST_IDLE;
        endcase

        if (launch) begin
            r_d.st   = ST_GATE;
            r_d.gate = 1'b1;
            r_d.tk   = '0;
            r_d.done = 1'b0;
            r_d.len  = r_q.ctrl.len;
            r_d.src  = r_q.ctrl.sel[SRC_W-1:0];
            tick_clr = 1'b1;
            if (!wr_ctrl) r_d.ctrl.start = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[CTRL_W-1:0] = r_q.ctrl;
                bus_rdata[BUSY_BIT]   = busy;
            end
            OFS_RESULT: bus_rdata[CNT_W-1:0] = r_q.result;
            default:    bus_rdata = '0;
        endcase
    end

    // R3: busy only rises after enable and start were both held
    p_busy_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(r_q.ctrl.en && r_q.ctrl.start));

    // R7: the result only moves once the count domain has closed its gate
    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.result) |-> $past(!ack_s && r_q.st == ST_DRAIN));

    // R9: interrupt is a single-cycle pulse
    p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R10: abort drops busy next cycle and keeps the result
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !r_q.ctrl.en) |=> (!busy && $stable(r_q.result)));

    // R4: the gate is only open during a measurement
    p_gate_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.gate |-> busy);
endmodule

// File: tb/freq_meter_test.sv
`timescale 1ns/1ps
module freq_meter_test;
    localparam int NSRC = 8;
    localparam int TDIV = 10;
    localparam logic [3:0] A_SPA  = 4'h0;
    localparam logic [3:0] A_CTRL = 4'h4;
    localparam logic [3:0] A_SPB  = 4'h8;
    localparam logic [3:0] A_RES  = 4'hC;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic [3:0]      bus_addr = 4'h0;
    logic [31:0]     bus_wdata = 32'h0;
    logic [31:0]     bus_rdata;
    logic [NSRC-1:0] src_clks;
    logic            irq;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;

    always #5 clk = ~clk;

    function automatic real per_ns(input int i);
        case (i)
            0: return 2.0;
            1: return 3.0;
            2: return 4.0;
            3: return 5.0;
            4: return 7.0;
            5: return 9.0;
            6: return 13.0;
            default: return 17.0;
        endcase
    endfunction

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic ck = 1'b0;
        assign src_clks[g] = ck;
        initial begin
            #(0.37 + 0.3 * g);
            forever #(per_ns(g) / 2.0) ck = ~ck;
        end
    end

    freq_meter #(.NUM_SRC(NSRC), .TICK_DIV(TDIV)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_clks  (src_clks),
        .irq       (irq)
    );

    always @(negedge clk) if (rst_n && irq) irq_cnt++;

    task automatic chk(input bit ok, input string req, input longint got, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, expv);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] cw(input int sel, input bit st, input bit ie,
                                       input bit co, input bit en, input int len);
        return {5'b0, 7'(sel), st, ie, co, en, 16'(len)};
    endfunction

    function automatic int ideal(input int src, input int n);
        return int'(real'((n + 1) * TDIV * 10) / per_ns(src));
    endfunction

    function automatic bit near(input int got, input int expv);
        return (got >= expv - 2) && (got <= expv + 2);
    endfunction

    task automatic wait_idle(output bit hung);
        logic [31:0] v;
        hung = 1'b0;
        for (int p = 0; p < 30000; p++) begin
            @(negedge clk);
            rd(A_CTRL, v);
            if (!v[31]) return;
        end
        hung = 1'b1;
    endtask

    task automatic measure(input int src, input int n, input bit ie, output int res);
        logic [31:0] v;
        bit hung;
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, cw(0, 0, 0, 0, 0, n));
        wr(A_CTRL, cw(src, 0, 0, 0, 0, n));
        wr(A_CTRL, cw(src, 1, ie, 0, 1, n));
        @(negedge clk);
        wait_idle(hung);
        chk(!hung, "R4 measurement completes", hung, 0);
        wr(A_CTRL, cw(src, 0, ie, 0, 0, n));
        rd(A_RES, v);
        res = int'(v[15:0]);
    endtask

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R4 run did not end got 0 expected 1");
        report();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int res, base, keep;
        bit hung, dropped;
        int ns[3] = '{0, 3, 9};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        rd(A_CTRL, v); chk(v == 0, "R11 control after reset", v, 0);
        rd(A_RES, v);  chk(v == 0, "R11 result after reset", v, 0);
        chk(irq == 1'b0, "R11 irq after reset", irq, 0);

        // R1 spare offsets
        wr(A_SPA, 32'hFFFF_FFFF);
        wr(A_SPB, 32'hFFFF_FFFF);
        rd(A_SPA, v);  chk(v == 0, "R1 offset 0x0 reads zero", v, 0);
        rd(A_SPB, v);  chk(v == 0, "R1 offset 0x8 reads zero", v, 0);
        rd(A_CTRL, v); chk(v == 0, "R1 spare writes leave control", v, 0);
        rd(A_RES, v);  chk(v == 0, "R1 spare writes leave result", v, 0);

        // R2 field readback
        wr(A_CTRL, cw(7'h55, 0, 1, 1, 0, 16'h1234));
        rd(A_CTRL, v);
        chk(v == cw(7'h55, 0, 1, 1, 0, 16'h1234), "R2 control fields read back", v,
            cw(7'h55, 0, 1, 1, 0, 16'h1234));
        wr(A_CTRL, 32'h0);

        // R3 busy timing, R2 start self-clear, R7 result ready at busy fall
        wr(A_CTRL, cw(2, 0, 0, 0, 0, 5));
        wr(A_CTRL, cw(2, 1, 0, 0, 1, 5));
        rd(A_CTRL, v);
        chk(v[31] == 1'b0, "R3 busy low in first cycle after write", v[31], 0);
        @(negedge clk);
        rd(A_CTRL, v);
        chk(v[31] == 1'b1, "R3 busy high in second cycle", v[31], 1);
        chk(v[19] == 1'b0, "R2 start bit clears once running", v[19], 0);
        wait_idle(hung);
        rd(A_RES, v);
        chk(!hung && near(int'(v[15:0]), ideal(2, 5)), "R7 result valid as busy falls",
            v[15:0], ideal(2, 5));
        wr(A_CTRL, cw(2, 0, 0, 0, 0, 5));

        // R4 R5 sweep of sources and gate lengths
        for (int s = 0; s < NSRC; s++) begin
            for (int k = 0; k < 3; k++) begin
                measure(s, ns[k], 1'b0, res);
                chk(near(res, ideal(s, ns[k])),
                    $sformatf("R4 R5 source %0d length %0d", s, ns[k]), res, ideal(s, ns[k]));
            end
        end
        chk(irq_cnt == 0, "R9 no irq with interrupt disabled", irq_cnt, 0);

        // R6 saturation boundary
        measure(0, 1300, 1'b0, res);
        chk(near(res, ideal(0, 1300)), "R6 count below limit not clipped", res, ideal(0, 1300));
        measure(0, 1400, 1'b0, res);
        chk(res == 65535, "R6 overflow reads 0xFFFF", res, 65535);

        // R9 single-shot interrupt
        base = irq_cnt;
        measure(4, 2, 1'b1, res);
        repeat (5) @(negedge clk);
        chk(irq_cnt - base == 1, "R9 one pulse per window", irq_cnt - base, 1);
        chk(near(res, ideal(4, 2)), "R4 interrupt run count", res, ideal(4, 2));

        // R8 continuous mode
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, cw(3, 0, 0, 0, 0, 4));
        base = irq_cnt;
        dropped = 1'b0;
        wr(A_CTRL, cw(3, 1, 1, 1, 1, 4));
        @(negedge clk);
        for (int w = 0; w < 3; w++) begin
            int polls = 0;
            do begin
                @(negedge clk);
                rd(A_CTRL, v);
                if (!v[31]) dropped = 1'b1;
                polls++;
            end while (!irq && polls < 1000);
            rd(A_RES, v);
            chk(irq && near(int'(v[15:0]), ideal(3, 4)),
                $sformatf("R8 window %0d result", w), v[15:0], ideal(3, 4));
        end
        chk(!dropped, "R8 busy stays high between windows", dropped, 0);
        chk(irq_cnt - base == 3, "R9 pulses match windows", irq_cnt - base, 3);

        // R10 abort during continuous run
        repeat (5) @(negedge clk);
        rd(A_RES, v);
        keep = int'(v[15:0]);
        base = irq_cnt;
        wr(A_CTRL, cw(3, 0, 1, 1, 0, 4));
        @(negedge clk);
        rd(A_CTRL, v);
        chk(v[31] == 1'b0, "R10 busy low after continuous abort", v[31], 0);
        repeat (100) @(negedge clk);
        rd(A_RES, v);
        chk(int'(v[15:0]) == keep, "R10 result kept after abort", v[15:0], keep);
        chk(irq_cnt == base, "R10 no irq after abort", irq_cnt - base, 0);

        // R10 abort of a single long window
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, cw(1, 0, 0, 0, 0, 200));
        wr(A_CTRL, cw(1, 1, 0, 0, 1, 200));
        repeat (30) @(negedge clk);
        rd(A_RES, v);
        keep = int'(v[15:0]);
        wr(A_CTRL, cw(1, 0, 0, 0, 0, 200));
        @(negedge clk);
        rd(A_CTRL, v);
        chk(v[31] == 1'b0, "R10 busy low after single abort", v[31], 0);
        repeat (50) @(negedge clk);
        rd(A_RES, v);
        chk(int'(v[15:0]) == keep, "R10 single abort keeps result", v[15:0], keep);
        measure(2, 3, 1'b0, res);
        chk(near(res, ideal(2, 3)), "R10 measurement after abort", res, ideal(2, 3));

        report();
        $finish;
    end
endmodule